// File: doc/BRIEF.md
# Translation Unit Control and Fault Registers

This block is the software-visible control plane of an address translation unit. Software writes a mode code into a control register to switch translation on, to hold traffic, or to turn translation off. The block turns that code into two level outputs for the datapath, `xlat_en` and `hold_req`. The datapath answers a hold request with `blk_ack`, and software can then poll a status bit that shows the hold has taken effect.

A page-table walker reports faults as single-cycle events that carry a cause code, a channel (read or write) and the faulting virtual address. Each accepted fault sets its own status bit and forces the unit into the hold mode. The address is captured in a per-channel register, but only while that channel has no fault pending. Software clears status bits by writing ones to a clear register, and it re-enables translation by writing the enable code again. The enable write is refused for as long as any fault bit is still set. A level interrupt stays high while any status bit is pending. The block also holds the page-table base frame number and a fixed version word.

Top module: `mmu_ctl_regs`

## Requirements
- R1: Writing 0x5 to offset 0x000 selects the enabled mode (`xlat_en`=1), writing 0x7 selects the hold mode (`hold_req`=1), and writing 0x0 selects the off mode (both 0). Any other value has no effect. Offset 0x000 reads back the code of the current mode. The two outputs are never high together.
- R2: Bit 0 of offset 0x008 reads 1 from the edge on which `blk_ack` is sampled high while the hold mode is already in force. It stays 1 until the mode leaves hold, and it reads 0 in every other mode.
- R3: A read-channel fault (`flt_is_write`=0) with cause c in 0..4 sets bit c of offset 0x060. A write-channel fault sets bit 16+c. The cause codes are 0 walk error, 1 page fault, 2 multi-hit, 3 access protection and 4 security protection. Cause values 5 to 7 are ignored.
- R4: Writing offset 0x064 clears every status bit of 0x060 whose position holds a 1 in the written data. If a fault sets a bit in the same cycle that the bit is cleared, the bit ends up set.
- R5: The read-channel faulting VA reads at 0x070 and the write-channel VA at 0x080. Each is captured on an accepted fault only if its channel had no status bit set at the start of that cycle. Otherwise it keeps its value.
- R6: A valid fault accepted in the enabled or hold mode puts the unit in hold mode at the next edge, and this takes priority over a control write in the same cycle. Faults that arrive in the off mode are ignored.
- R7: A write of the enable code while any status bit is set is ignored. Once all bits are cleared, the enable code resumes translation.
- R8: `irq` is high exactly while at least one status bit of 0x060 is set.
- R9: Offset 0x00C holds a PFN_W-bit page-table base frame number. It is writable, drives `pt_base_pfn`, and reads back with the upper bits as zero.
- R10: Offset 0x034 reads the 11-bit version {major[3:0], minor[6:0]} in bits 31:21 with all other bits zero, and writes to it are ignored. Unmapped offsets read zero.
- R11: After reset the unit is off, and all status bits, captured addresses and the base frame number are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| flt_valid | input | 1 | Fault event from the walker |
| flt_is_write | input | 1 | Fault channel: 1 means write, 0 means read |
| flt_cause | input | CW | Fault cause code |
| flt_va | input | VA_W | Faulting virtual address |
| blk_ack | input | 1 | Datapath has drained and is holding |
| xlat_en | output | 1 | Translation enabled |
| hold_req | output | 1 | Hold traffic request |
| irq | output | 1 | Fault interrupt, level |
| pt_base_pfn | output | PFN_W | Page-table base frame number |

## Verification
Read data follows `bus_addr` within the same cycle. A register write, a fault event or a clear becomes visible at the first rising edge after it is driven. The blocked bit also needs one edge after `blk_ack`, and only if the hold was already in force before that edge. The bench drives all inputs on falling edges and updates a behavioural model on each rising edge. It compares every output and the read data for the current offset 2 ns after that rising edge. Directed reads are sampled just after the falling edge that follows a write, once exactly one edge has passed.

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs #(
  parameter int ADDR_W    = 12,
  parameter int VA_W      = 32,
  parameter int PFN_W     = 20,
  parameter int NCAUSE    = 5,
  parameter int WR_BASE   = 16,
  parameter int VER_MAJOR = 5,
  parameter int VER_MINOR = 0,
  localparam int CW       = $clog2(NCAUSE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flt_valid,
  input  logic              flt_is_write,
  input  logic [CW-1:0]     flt_cause,
  input  logic [VA_W-1:0]   flt_va,
  input  logic              blk_ack,
  output logic              xlat_en,
  output logic              hold_req,
  output logic              irq,
  output logic [PFN_W-1:0]  pt_base_pfn
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h008);
  localparam logic [ADDR_W-1:0] A_PFN  = ADDR_W'('h00C);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'('h034);
  localparam logic [ADDR_W-1:0] A_IST  = ADDR_W'('h060);
  localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'('h064);
  localparam logic [ADDR_W-1:0] A_RVA  = ADDR_W'('h070);
  localparam logic [ADDR_W-1:0] A_WVA  = ADDR_W'('h080);
  localparam logic [31:0] CODE_OFF  = 32'h0;
  localparam logic [31:0] CODE_ON   = 32'h5;
  localparam logic [31:0] CODE_HOLD = 32'h7;
  localparam logic [10:0] VERSION   = {4'(VER_MAJOR), 7'(VER_MINOR)};

  typedef enum logic [1:0] {M_OFF, M_ON, M_HOLD} mode_t;

  mode_t             mode_q, mode_d;
  logic              blocked_q;
  logic [NCAUSE-1:0] rd_st_q, wr_st_q, flt_vec, rd_clr, wr_clr;
  logic [VA_W-1:0]   rd_va_q, wr_va_q;
  logic [PFN_W-1:0]  pfn_q;

  wire wr_ctrl  = bus_wr && bus_addr == A_CTRL;
  wire wr_pfn   = bus_wr && bus_addr == A_PFN;
  wire wr_iclr  = bus_wr && bus_addr == A_ICLR;
  wire pending  = |rd_st_q || |wr_st_q;
  wire flt_ok   = flt_valid && int'(flt_cause) < NCAUSE && mode_q != M_OFF;
  wire flt_rd   = flt_ok && !flt_is_write;
  wire flt_wr   = flt_ok && flt_is_write;

  assign flt_vec = flt_ok ? (NCAUSE'(1) << flt_cause) : '0;
  assign rd_clr  = wr_iclr ? bus_wdata[NCAUSE-1:0] : '0;
  assign wr_clr  = wr_iclr ? bus_wdata[WR_BASE +: NCAUSE] : '0;

  always_comb begin
    mode_d = mode_q;
    if (wr_ctrl) begin
      if (bus_wdata == CODE_ON && !pending) mode_d = M_ON;
      else if (bus_wdata == CODE_HOLD)      mode_d = M_HOLD;
      else if (bus_wdata == CODE_OFF)       mode_d = M_OFF;
    end
    if (flt_ok) mode_d = M_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_OFF;
      blocked_q <= 1'b0;
      rd_st_q   <= '0;
      wr_st_q   <= '0;
      rd_va_q   <= '0;
      wr_va_q   <= '0;
      pfn_q     <= '0;
    end else begin
      mode_q    <= mode_d;
      blocked_q <= mode_q == M_HOLD && mode_d == M_HOLD && (blocked_q || blk_ack);
      rd_st_q   <= (rd_st_q & ~rd_clr) | (flt_rd ? flt_vec : '0);
      wr_st_q   <= (wr_st_q & ~wr_clr) | (flt_wr ? flt_vec : '0);
      if (flt_rd && rd_st_q == '0) rd_va_q <= flt_va;
      if (flt_wr && wr_st_q == '0) wr_va_q <= flt_va;
      if (wr_pfn) pfn_q <= bus_wdata[PFN_W-1:0];
    end
  end

  assign xlat_en     = mode_q == M_ON;
  assign hold_req    = mode_q == M_HOLD;
  assign irq         = pending;
  assign pt_base_pfn = pfn_q;

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  bus_rdata = mode_q == M_ON ? CODE_ON : (mode_q == M_HOLD ? CODE_HOLD : CODE_OFF);
      A_STAT:  bus_rdata = {31'b0, blocked_q};
      A_PFN:   bus_rdata = 32'(pfn_q);
      A_VER:   bus_rdata = {VERSION, 21'b0};
      A_IST:   bus_rdata = 32'(rd_st_q) | (32'(wr_st_q) << WR_BASE);
      A_RVA:   bus_rdata = 32'(rd_va_q);
      A_WVA:   bus_rdata = 32'(wr_va_q);
      default: bus_rdata = 32'h0;
    endcase
  end

  assert_mode_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(xlat_en && hold_req));

  assert_blocked_in_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_q |-> hold_req);

  assert_fault_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && int'(flt_cause) < NCAUSE && (xlat_en || hold_req)) |=> hold_req);

  assert_rd_va_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_st_q) |=> $stable(rd_va_q));

  assert_wr_va_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_st_q) |=> $stable(wr_va_q));

  assert_no_run_with_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !xlat_en);

  assert_irq_needs_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(bus_wr && bus_addr == A_ICLR)) |=> irq);

endmodule

// File: tb/mmu_ctl_regs_test.sv
module mmu_ctl_regs_test;
  localparam int PFN_W = 20;

  logic        clk = 0, rst_n = 0;
  logic        bus_wr = 0;
  logic [11:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        flt_valid = 0, flt_is_write = 0, blk_ack = 0;
  logic [2:0]  flt_cause = 0;
  logic [31:0] flt_va = 0;
  logic        xlat_en, hold_req, irq;
  logic [PFN_W-1:0] pt_base_pfn;

  int tests = 0, fails = 0;

  mmu_ctl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flt_valid(flt_valid),
    .flt_is_write(flt_is_write), .flt_cause(flt_cause), .flt_va(flt_va),
    .blk_ack(blk_ack), .xlat_en(xlat_en), .hold_req(hold_req), .irq(irq),
    .pt_base_pfn(pt_base_pfn));

  always #4 clk = ~clk;

  // behavioural model: mode 0 off, 1 on, 2 hold
  int          m_mode = 0;
  bit          m_blk = 0;
  bit [31:0]   m_rst = 0, m_wst = 0, m_rva = 0, m_wva = 0, m_pfn = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_blk = 0; m_rst = 0; m_wst = 0; m_rva = 0; m_wva = 0; m_pfn = 0;
    end else begin
      automatic bit pend = (m_rst | m_wst) != 0;
      automatic bit ok = flt_valid && flt_cause < 5 && m_mode != 0;
      automatic int nm = m_mode;
      automatic bit [31:0] ors = m_rst, ows = m_wst;
      if (bus_wr && bus_addr == 12'h000) begin
        if (bus_wdata == 5 && !pend) nm = 1;
        else if (bus_wdata == 7) nm = 2;
        else if (bus_wdata == 0) nm = 0;
      end
      if (ok) nm = 2;
      m_blk = m_mode == 2 && nm == 2 && (m_blk || blk_ack);
      m_mode = nm;
      if (bus_wr && bus_addr == 12'h064) begin
        m_rst = m_rst & ~(bus_wdata & 32'h1F);
        m_wst = m_wst & ~((bus_wdata >> 16) & 32'h1F);
      end
      if (ok && !flt_is_write) begin
        if (ors == 0) m_rva = flt_va;
        m_rst = m_rst | (32'h1 << flt_cause);
      end
      if (ok && flt_is_write) begin
        if (ows == 0) m_wva = flt_va;
        m_wst = m_wst | (32'h1 << flt_cause);
      end
      if (bus_wr && bus_addr == 12'h00C) m_pfn = bus_wdata & ((32'h1 << PFN_W) - 1);
    end
  end

  function automatic bit [31:0] exp_rd(logic [11:0] a);
    case (a)
      12'h000: return m_mode == 1 ? 32'h5 : (m_mode == 2 ? 32'h7 : 32'h0);
      12'h008: return {31'b0, m_blk};
      12'h00C: return m_pfn;
      12'h034: return 32'h5000_0000;
      12'h060: return m_rst | (m_wst << 16);
      12'h070: return m_rva;
      12'h080: return m_wva;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(logic [11:0] a);
    case (a)
      12'h000: return "R1 ctrl readback";
      12'h008: return "R2 blocked status";
      12'h00C: return "R9 base pfn";
      12'h060: return "R3 fault status";
      12'h070, 12'h080: return "R5 fault va";
      default: return "R10 version/unmapped";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk("R1 xlat_en", 32'(xlat_en), 32'(m_mode == 1));
      chk("R1 hold_req", 32'(hold_req), 32'(m_mode == 2));
      chk("R8 irq", 32'(irq), 32'((m_rst | m_wst) != 0));
      chk("R9 pt_base_pfn", 32'(pt_base_pfn), m_pfn);
      chk(tag_of(bus_addr), bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic idle();
    bus_wr = 0; flt_valid = 0; flt_is_write = 0; flt_cause = 0; blk_ack = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); idle(); bus_wr = 1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic fault(bit w, logic [2:0] c, logic [31:0] va);
    @(negedge clk); idle(); flt_valid = 1; flt_is_write = w; flt_cause = c; flt_va = va;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk); idle(); bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd_chk(12'h000, 32'h0, "R11 reset mode");
    chk("R11 reset xlat_en", 32'(xlat_en), 32'h0);
    rd_chk(12'h060, 32'h0, "R11 reset status");
    rd_chk(12'h070, 32'h0, "R11 reset read va");
    rd_chk(12'h00C, 32'h0, "R11 reset pfn");
    rd_chk(12'h034, 32'h5000_0000, "R10 version");
    wr(12'h034, 32'hFFFF_FFFF);
    rd_chk(12'h034, 32'h5000_0000, "R10 version read-only");
    rd_chk(12'h100, 32'h0, "R10 unmapped");
    wr(12'h00C, 32'hFFFF_FFFF);
    rd_chk(12'h00C, 32'h000F_FFFF, "R9 pfn width");
    chk("R9 pfn port", 32'(pt_base_pfn), 32'h000F_FFFF);
    wr(12'h000, 32'h3);
    rd_chk(12'h000, 32'h0, "R1 invalid code ignored");
    wr(12'h000, 32'h5);
    rd_chk(12'h000, 32'h5, "R1 enable code");
    chk("R1 xlat_en on", 32'(xlat_en), 32'h1);
    fault(0, 3'd1, 32'h1234_5000);
    rd_chk(12'h060, 32'h0000_0002, "R3 read page fault bit");
    chk("R6 fault forces hold", 32'(hold_req), 32'h1);
    chk("R8 irq raised", 32'(irq), 32'h1);
    rd_chk(12'h070, 32'h1234_5000, "R5 read va captured");
    fault(0, 3'd3, 32'h0000_AAAA);
    rd_chk(12'h060, 32'h0000_000A, "R3 second read cause");
    rd_chk(12'h070, 32'h1234_5000, "R5 read va kept");
    fault(1, 3'd4, 32'h0BEE_F000);
    rd_chk(12'h060, 32'h0010_000A, "R3 write security bit");
    rd_chk(12'h080, 32'h0BEE_F000, "R5 write va captured");
    rd_chk(12'h008, 32'h0, "R2 not blocked before ack");
    @(negedge clk); idle(); blk_ack = 1;
    rd_chk(12'h008, 32'h1, "R2 blocked after ack");
    wr(12'h000, 32'h5);
    rd_chk(12'h000, 32'h7, "R7 enable refused while pending");
    wr(12'h064, 32'h0000_000A);
    rd_chk(12'h060, 32'h0010_0000, "R4 clear read bits");
    chk("R8 irq still high", 32'(irq), 32'h1);
    @(negedge clk); idle(); bus_wr = 1; bus_addr = 12'h064; bus_wdata = 32'h0001_0000;
    flt_valid = 1; flt_is_write = 1; flt_cause = 3'd0; flt_va = 32'h5;
    rd_chk(12'h060, 32'h0011_0000, "R4 set wins over clear");
    wr(12'h064, 32'h0011_0000);
    rd_chk(12'h060, 32'h0, "R4 all cleared");
    chk("R8 irq low", 32'(irq), 32'h0);
    fault(0, 3'd5, 32'h9);
    rd_chk(12'h060, 32'h0, "R3 bad cause ignored");
    wr(12'h000, 32'h5);
    rd_chk(12'h000, 32'h5, "R7 resume after clear");
    rd_chk(12'h008, 32'h0, "R2 blocked clears");
    wr(12'h000, 32'h7);
    rd_chk(12'h000, 32'h7, "R1 hold code");
    wr(12'h000, 32'h0);
    rd_chk(12'h000, 32'h0, "R1 off code");
    fault(0, 3'd1, 32'h77);
    rd_chk(12'h060, 32'h0, "R6 fault ignored when off");
    chk("R6 irq stays low when off", 32'(irq), 32'h0);

    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      idle();
      case ($urandom_range(0, 6))
        0: begin
          bus_addr = 12'h000;
          case ($urandom_range(0, 4))
            0: bus_wdata = 0; 1: bus_wdata = 5; 2: bus_wdata = 7; 3: bus_wdata = 5; default: bus_wdata = 2;
          endcase
        end
        1: begin bus_addr = 12'h064; bus_wdata = $urandom; end
        2: begin bus_addr = 12'h00C; bus_wdata = $urandom; end
        3: bus_addr = 12'h060;
        4: bus_addr = 12'h070;
        5: bus_addr = 12'h080;
        default: bus_addr = 12'h008;
      endcase
      bus_wr = $urandom_range(0, 2) == 0;
      flt_valid = $urandom_range(0, 3) == 0;
      flt_is_write = $urandom_range(0, 1) == 1;
      flt_cause = 3'($urandom_range(0, 6));
      flt_va = $urandom;
      blk_ack = $urandom_range(0, 1) == 1;
    end
    @(negedge clk); idle();
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule